// File: doc/BRIEF.md
# Two-Class Packet Priority Classifier and Scheduler

This block takes one parsed packet descriptor per cycle, decides whether it belongs to the high or the low class, and places it in one of two queues. The descriptor carries a handle and the header fields that were already extracted upstream. These fields are the source port identity, an IPv4 or IPv6 address, the ToS/traffic-class byte, an optional UDP port and the IPv6 flow label. A held output slot drains the two queues. When the slot loads, it always takes from the high queue if that queue holds anything.

The class comes from a small rule table that a host register port writes, one entry per write. Every entry has a valid bit and one of four match kinds, and each kind compares a fixed combination of fields. Only descriptors that arrive on the DMZ or WAN ports are classified. Descriptors from LAN ports, and descriptors that match no valid rule, go to the low class.

The output slot is a small state machine with three states. `ST_IDLE` means the slot is empty. `ST_HOLD_HI` and `ST_HOLD_LO` mean the slot holds a descriptor taken from the high or the low queue. The slot is free in `ST_IDLE`, or in a hold state when `out_ready` is high. When the slot is free, it moves to `ST_HOLD_HI` if the high queue is not empty. Otherwise it moves to `ST_HOLD_LO` if the low queue is not empty. Otherwise it moves to `ST_IDLE`. When the slot is not free, the state does not change.

Top module: `prio_sched`

## Requirements
- R1: There are exactly two classes. `out_high`=1 marks the high class. A descriptor that hits no valid rule is low class.
- R2: Kind 0 (IPv4 + UDP port) hits when `in_is_v6`=0, `in_udp_valid`=1, address bits [31:0] are equal and the 16-bit UDP port is equal.
- R3: Kind 1 (IPv4 + ToS) hits when `in_is_v6`=0, address bits [31:0] are equal and the 8-bit ToS is equal.
- R4: Kind 2 (IPv4 + ToS + UDP port) hits only when `in_is_v6`=0, `in_udp_valid`=1, and address bits [31:0], ToS and UDP port are all equal.
- R5: Kind 3 (IPv6) hits when `in_is_v6`=1 and all of the following are equal: the full 128-bit address, the 8-bit traffic class and the 20-bit flow label.
- R6: Only descriptors with `in_src` = 2 (DMZ) or 3 (WAN) can be high class. Sources 0 and 1 are always low.
- R7: An entry with its valid bit clear never hits. A table write applies to descriptors offered after the write's clock edge.
- R8: Strict priority: whenever the slot loads while the high queue is non-empty, it takes from the high queue. Within a class, order is first in, first out.
- R9: Each queue has a full flag. A descriptor offered to a queue whose full flag is set is dropped, and that queue's drop counter increments, saturating at all ones.
- R10: While `out_valid`=1 and `out_ready`=0, `out_handle` and `out_high` stay stable.
- R11: After reset, `out_valid`, both full flags and both drop counters are 0, and the rule table is all invalid.
- R12: A descriptor accepted at clock edge k, with an empty slot, appears on the output after edge k+1. A cycle with `in_valid`=0 enqueues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Rule table write strobe |
| cfg_idx | input | IDX_W | Rule entry index |
| cfg_valid | input | 1 | Valid bit of the written entry |
| cfg_kind | input | 2 | Match kind 0..3 |
| cfg_addr | input | 128 | Rule address (IPv4 rules use bits [31:0]) |
| cfg_tclass | input | 8 | Rule ToS / traffic class |
| cfg_udp | input | 16 | Rule UDP port |
| cfg_flow | input | 20 | Rule flow label |
| in_valid | input | 1 | Descriptor offered this cycle |
| in_src | input | 2 | Source port: 0,1 LAN; 2 DMZ; 3 WAN |
| in_is_v6 | input | 1 | Packet is IPv6 |
| in_addr | input | 128 | Packet address (IPv4 in bits [31:0]) |
| in_tclass | input | 8 | ToS or traffic class |
| in_udp_valid | input | 1 | A UDP port field is present |
| in_udp_port | input | 16 | UDP port |
| in_flow | input | 20 | IPv6 flow label |
| in_handle | input | HANDLE_W | Descriptor handle |
| out_valid | output | 1 | Output slot holds a descriptor |
| out_ready | input | 1 | Downstream takes the slot this cycle |
| out_handle | output | HANDLE_W | Scheduled handle |
| out_high | output | 1 | Scheduled descriptor is high class |
| full_hi | output | 1 | High queue full |
| full_lo | output | 1 | Low queue full |
| drop_hi | output | DROP_W | High queue drop count |
| drop_lo | output | DROP_W | Low queue drop count |

## Verification
A vector table covers each match kind with descriptors that hit exactly, and with descriptors that differ in a single field by one step. This shows that every field of a kind really takes part in the compare. Further vectors present the same fields from a LAN source, under the wrong IP version, without a UDP port, and against a disabled entry; these show that source gating and version gating are kept apart from field equality. An interleaved low/high burst with the output stalled shows strict priority against FIFO order. Overfilling both queues, and then saturating one counter, shows that drops are counted separately for each queue.

// File: rtl/prio_pkg.sv
package prio_pkg;

    typedef enum logic [1:0] {
        K_V4_PORT     = 2'd0,
        K_V4_TOS      = 2'd1,
        K_V4_TOS_PORT = 2'd2,
        K_V6_FLOW     = 2'd3
    } rule_kind_e;

    typedef struct packed {
        logic         valid;
        rule_kind_e   kind;
        logic [127:0] addr;
        logic [7:0]   tclass;
        logic [15:0]  udp;
        logic [19:0]  flow;
    } prio_rule_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD_HI = 2'd1,
        ST_HOLD_LO = 2'd2
    } slot_state_e;

    localparam logic [1:0] SRC_DMZ = 2'd2;
    localparam logic [1:0] SRC_WAN = 2'd3;

endpackage

// File: rtl/prio_classifier.sv
module prio_classifier
    import prio_pkg::*;
#(
    parameter int NUM_RULES = 8,
    localparam int IDX_W = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  prio_rule_t       cfg_rule,
    input  logic [1:0]       in_src,
    input  logic             in_is_v6,
    input  logic [127:0]     in_addr,
    input  logic [7:0]       in_tclass,
    input  logic             in_udp_valid,
    input  logic [15:0]      in_udp_port,
    input  logic [19:0]      in_flow,
    output logic             cls_high
);

    prio_rule_t           table_q [NUM_RULES];
    logic [NUM_RULES-1:0] hit;
    logic                 src_eligible;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_RULES; i++) table_q[i] <= '0;
        end else if (cfg_we) begin
            table_q[cfg_idx] <= cfg_rule;
        end
    end

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        logic v4_eq, v6_eq, tc_eq, port_eq, flow_eq, kind_ok;
        assign v4_eq   = (table_q[g].addr[31:0] == in_addr[31:0]);
        assign v6_eq   = (table_q[g].addr == in_addr);
        assign tc_eq   = (table_q[g].tclass == in_tclass);
        assign port_eq = in_udp_valid && (table_q[g].udp == in_udp_port);
        assign flow_eq = (table_q[g].flow == in_flow);
        always_comb begin
            unique case (table_q[g].kind)
                K_V4_PORT:     kind_ok = !in_is_v6 && v4_eq && port_eq;
                K_V4_TOS:      kind_ok = !in_is_v6 && v4_eq && tc_eq;
                K_V4_TOS_PORT: kind_ok = !in_is_v6 && v4_eq && tc_eq && port_eq;
                K_V6_FLOW:     kind_ok = in_is_v6 && v6_eq && tc_eq && flow_eq;
                default:       kind_ok = 1'b0;
            endcase
        end
        assign hit[g] = table_q[g].valid && kind_ok;
    end

    assign src_eligible = (in_src == SRC_DMZ) || (in_src == SRC_WAN);
    assign cls_high     = src_eligible && (|hit);

endmodule

// File: rtl/prio_fifo.sv
module prio_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);

    // R9: the enqueue gate upstream must never push into a full queue
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R8: the slot machine must never pop an empty queue
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

endmodule

// File: rtl/prio_slot_fsm.sv
module prio_slot_fsm
    import prio_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_empty,
    input  logic             lo_empty,
    input  logic [WIDTH-1:0] hi_data,
    input  logic [WIDTH-1:0] lo_data,
    input  logic             out_ready,
    output logic             pop_hi,
    output logic             pop_lo,
    output logic             out_valid,
    output logic             out_high,
    output logic [WIDTH-1:0] out_data
);

    slot_state_e state_q, state_d;
    logic        take;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pop_hi  = 1'b0;
        pop_lo  = 1'b0;
        unique case (state_q)
            ST_IDLE:                take = 1'b1;
            ST_HOLD_HI, ST_HOLD_LO: take = out_ready;
            default:                take = 1'b1;
        endcase
        if (take) begin
            if (!hi_empty) begin
                state_d = ST_HOLD_HI;
                pop_hi  = 1'b1;
            end else if (!lo_empty) begin
                state_d = ST_HOLD_LO;
                pop_lo  = 1'b1;
            end else begin
                state_d = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      out_data <= '0;
        else if (pop_hi) out_data <= hi_data;
        else if (pop_lo) out_data <= lo_data;
    end

    always_comb begin
        out_valid = (state_q != ST_IDLE);
        out_high  = (state_q == ST_HOLD_HI);
    end

    // R10: a stalled slot keeps its contents
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_high)));

endmodule

// File: rtl/prio_sched.sv
module prio_sched
    import prio_pkg::*;
#(
    parameter int NUM_RULES   = 8,
    parameter int QUEUE_DEPTH = 4,
    parameter int HANDLE_W    = 16,
    parameter int DROP_W      = 8,
    localparam int IDX_W = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic                cfg_valid,
    input  logic [1:0]          cfg_kind,
    input  logic [127:0]        cfg_addr,
    input  logic [7:0]          cfg_tclass,
    input  logic [15:0]         cfg_udp,
    input  logic [19:0]         cfg_flow,
    input  logic                in_valid,
    input  logic [1:0]          in_src,
    input  logic                in_is_v6,
    input  logic [127:0]        in_addr,
    input  logic [7:0]          in_tclass,
    input  logic                in_udp_valid,
    input  logic [15:0]         in_udp_port,
    input  logic [19:0]         in_flow,
    input  logic [HANDLE_W-1:0] in_handle,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [HANDLE_W-1:0] out_handle,
    output logic                out_high,
    output logic                full_hi,
    output logic                full_lo,
    output logic [DROP_W-1:0]   drop_hi,
    output logic [DROP_W-1:0]   drop_lo
);

    localparam int NUM_Q = 2;   // index 1 = high class, 0 = low class

    prio_rule_t          cfg_rule;
    logic                cls_high;
    logic [NUM_Q-1:0]    q_push, q_pop, q_full, q_empty;
    logic [HANDLE_W-1:0] q_dout [NUM_Q];
    logic [DROP_W-1:0]   drop_q [NUM_Q];

    always_comb begin
        cfg_rule.valid  = cfg_valid;
        cfg_rule.kind   = rule_kind_e'(cfg_kind);
        cfg_rule.addr   = cfg_addr;
        cfg_rule.tclass = cfg_tclass;
        cfg_rule.udp    = cfg_udp;
        cfg_rule.flow   = cfg_flow;
    end

    prio_classifier #(.NUM_RULES(NUM_RULES)) u_cls (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_idx      (cfg_idx),
        .cfg_rule     (cfg_rule),
        .in_src       (in_src),
        .in_is_v6     (in_is_v6),
        .in_addr      (in_addr),
        .in_tclass    (in_tclass),
        .in_udp_valid (in_udp_valid),
        .in_udp_port  (in_udp_port),
        .in_flow      (in_flow),
        .cls_high     (cls_high)
    );

    for (genvar c = 0; c < NUM_Q; c++) begin : g_class
        localparam logic IS_HI = (c == 1);
        logic offered;
        assign offered   = in_valid && (cls_high == IS_HI);
        assign q_push[c] = offered && !q_full[c];

        prio_fifo #(.DEPTH(QUEUE_DEPTH), .WIDTH(HANDLE_W)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[c]),
            .din   (in_handle),
            .pop   (q_pop[c]),
            .dout  (q_dout[c]),
            .empty (q_empty[c]),
            .full  (q_full[c])
        );

        always_ff @(posedge clk) begin
            if (!rst_n)
                drop_q[c] <= '0;
            else if (offered && q_full[c] && (drop_q[c] != '1))
                drop_q[c] <= drop_q[c] + 1'b1;
        end

        // R9: an offer to a full, unsaturated queue bumps its own counter
        p_drop_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (offered && q_full[c] && (drop_q[c] != '1)) |=> (drop_q[c] == $past(drop_q[c]) + 1'b1));
    end

    prio_slot_fsm #(.WIDTH(HANDLE_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_empty  (q_empty[1]),
        .lo_empty  (q_empty[0]),
        .hi_data   (q_dout[1]),
        .lo_data   (q_dout[0]),
        .out_ready (out_ready),
        .pop_hi    (q_pop[1]),
        .pop_lo    (q_pop[0]),
        .out_valid (out_valid),
        .out_high  (out_high),
        .out_data  (out_handle)
    );

    assign full_hi = q_full[1];
    assign full_lo = q_full[0];
    assign drop_hi = drop_q[1];
    assign drop_lo = drop_q[0];

    // R8: the low queue is served only while the high queue is empty
    p_strict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop[0] |-> q_empty[1]);
    // R6: LAN sources never enter the high queue
    p_lan_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_src[1]) |-> !q_push[1]);
    // R12: nothing is enqueued without an offer
    p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (q_push == '0));

endmodule

// File: tb/prio_sched_bench.sv
module prio_sched_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_RULES  = 8;
    localparam int HW         = 16;
    localparam int DW         = 8;
    localparam logic [95:0] V6_HI = 96'hFD00_0000_0000_0000_0000_0001;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cfg_we, cfg_valid;
    logic [2:0]     cfg_idx;
    logic [1:0]     cfg_kind;
    logic [127:0]   cfg_addr;
    logic [7:0]     cfg_tclass;
    logic [15:0]    cfg_udp;
    logic [19:0]    cfg_flow;
    logic           in_valid, in_is_v6, in_udp_valid;
    logic [1:0]     in_src;
    logic [127:0]   in_addr;
    logic [7:0]     in_tclass;
    logic [15:0]    in_udp_port;
    logic [19:0]    in_flow;
    logic [HW-1:0]  in_handle;
    logic           out_valid, out_ready, out_high, full_hi, full_lo;
    logic [HW-1:0]  out_handle;
    logic [DW-1:0]  drop_hi, drop_lo;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_sched #(.NUM_RULES(NUM_RULES), .QUEUE_DEPTH(4), .HANDLE_W(HW), .DROP_W(DW)) u_prio_sched (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_tclass(cfg_tclass), .cfg_udp(cfg_udp), .cfg_flow(cfg_flow),
        .in_valid(in_valid), .in_src(in_src), .in_is_v6(in_is_v6), .in_addr(in_addr),
        .in_tclass(in_tclass), .in_udp_valid(in_udp_valid), .in_udp_port(in_udp_port),
        .in_flow(in_flow), .in_handle(in_handle),
        .out_valid(out_valid), .out_ready(out_ready), .out_handle(out_handle), .out_high(out_high),
        .full_hi(full_hi), .full_lo(full_lo), .drop_hi(drop_hi), .drop_lo(drop_lo)
    );

    // vector: src[2] v6[1] udpv[1] a32[32] tc[8] port[16] flow[20] exp_high[1]
    localparam int NV = 14;
    localparam logic [80:0] VEC [NV] = '{
        {2'd2, 1'b0, 1'b1, 32'h0A000001, 8'h00, 16'd5060, 20'h0,     1'b1}, // R2 hit
        {2'd2, 1'b0, 1'b1, 32'h0A000001, 8'h00, 16'd5061, 20'h0,     1'b0}, // R2 port off by one
        {2'd3, 1'b0, 1'b0, 32'h0A000002, 8'hB8, 16'd0,    20'h0,     1'b1}, // R3 hit
        {2'd3, 1'b0, 1'b0, 32'h0A000002, 8'hB9, 16'd0,    20'h0,     1'b0}, // R3 tos off by one
        {2'd2, 1'b0, 1'b1, 32'h0A000003, 8'h28, 16'd4000, 20'h0,     1'b1}, // R4 hit
        {2'd2, 1'b0, 1'b1, 32'h0A000003, 8'h28, 16'd4001, 20'h0,     1'b0}, // R4 port off
        {2'd3, 1'b1, 1'b0, 32'h00000004, 8'h2E, 16'd0,    20'h12345, 1'b1}, // R5 hit
        {2'd3, 1'b1, 1'b0, 32'h00000004, 8'h2E, 16'd0,    20'h12344, 1'b0}, // R5 flow off
        {2'd0, 1'b0, 1'b1, 32'h0A000001, 8'h00, 16'd5060, 20'h0,     1'b0}, // R6 LAN0
        {2'd1, 1'b1, 1'b0, 32'h00000004, 8'h2E, 16'd0,    20'h12345, 1'b0}, // R6 LAN1
        {2'd2, 1'b0, 1'b0, 32'h0A000005, 8'h00, 16'd0,    20'h0,     1'b0}, // R7 invalid entry
        {2'd3, 1'b0, 1'b0, 32'h0A000001, 8'h00, 16'd5060, 20'h0,     1'b0}, // R2 no UDP field
        {2'd3, 1'b1, 1'b1, 32'h0A000001, 8'h00, 16'd5060, 20'h0,     1'b0}, // R1 wrong version
        {2'd2, 1'b0, 1'b0, 32'h00000004, 8'h2E, 16'd0,    20'h12345, 1'b0}  // R5 v4 miss
    };

    function automatic logic [127:0] mk_addr(input logic v6, input logic [31:0] a);
        return v6 ? {V6_HI, a} : {96'h0, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_rule(input int idx, input logic v, input logic [1:0] k,
                              input logic [127:0] a, input logic [7:0] tc,
                              input logic [15:0] p, input logic [19:0] f);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_valid = v; cfg_kind = k;
        cfg_addr = a; cfg_tclass = tc; cfg_udp = p; cfg_flow = f;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic offer(input logic [80:0] v, input logic [HW-1:0] h);
        in_src = v[80:79]; in_is_v6 = v[78]; in_udp_valid = v[77];
        in_addr = mk_addr(v[78], v[76:45]); in_tclass = v[44:37];
        in_udp_port = v[36:21]; in_flow = v[20:1]; in_handle = h;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // low-class and high-class templates for queue tests
    localparam logic [80:0] LO_T = {2'd0, 1'b0, 1'b0, 32'h0, 8'h0, 16'd0, 20'h0, 1'b0};
    localparam logic [80:0] HI_T = {2'd2, 1'b0, 1'b1, 32'h0A000001, 8'h00, 16'd5060, 20'h0, 1'b1};

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0; cfg_kind = '0;
        cfg_addr = '0; cfg_tclass = '0; cfg_udp = '0; cfg_flow = '0;
        in_valid = 1'b0; in_src = '0; in_is_v6 = 1'b0; in_addr = '0; in_tclass = '0;
        in_udp_valid = 1'b0; in_udp_port = '0; in_flow = '0; in_handle = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11 out_valid", out_valid, 0);
        check("R11 full_hi", full_hi, 0);
        check("R11 full_lo", full_lo, 0);
        check("R11 drop_hi", drop_hi, 0);
        check("R11 drop_lo", drop_lo, 0);
        // R11: empty table -> a would-be hit is low
        offer(HI_T, 16'h0777);
        @(negedge clk);
        check("R11 empty table class", out_high, 0);

        write_rule(0, 1'b1, 2'd0, mk_addr(0, 32'h0A000001), 8'h00, 16'd5060, 20'h0);
        write_rule(1, 1'b1, 2'd1, mk_addr(0, 32'h0A000002), 8'hB8, 16'd0,    20'h0);
        write_rule(2, 1'b1, 2'd2, mk_addr(0, 32'h0A000003), 8'h28, 16'd4000, 20'h0);
        write_rule(3, 1'b1, 2'd3, mk_addr(1, 32'h00000004), 8'h2E, 16'd0,    20'h12345);
        write_rule(4, 1'b0, 2'd1, mk_addr(0, 32'h0A000005), 8'h00, 16'd0,    20'h0);
        repeat (2) @(negedge clk);

        // vector walk, R12 latency: offer at edge k, output after edge k+1
        for (int i = 0; i < NV; i++) begin
            offer(VEC[i], HW'(i));
            @(negedge clk);
            check($sformatf("R12 vec%0d valid", i), out_valid, 1);
            check($sformatf("R1 vec%0d class", i), out_high, VEC[i][0]);
            check($sformatf("R12 vec%0d handle", i), out_handle, i);
        end
        @(negedge clk);
        check("R12 drained", out_valid, 0);

        // R7: enabling entry 4 makes vector 10 hit
        write_rule(4, 1'b1, 2'd1, mk_addr(0, 32'h0A000005), 8'h00, 16'd0, 20'h0);
        offer(VEC[10], 16'h00AA);
        @(negedge clk);
        check("R7 enabled entry hits", out_high, 1);
        @(negedge clk);

        // R12: in_valid low with matching fields enqueues nothing
        in_src = 2'd2; in_is_v6 = 1'b0; in_udp_valid = 1'b1;
        in_addr = mk_addr(0, 32'h0A000001); in_udp_port = 16'd5060; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 idle offer ignored", out_valid, 0);

        // R8 / R10: stalled output, interleaved classes
        out_ready = 1'b0;
        offer(LO_T, 16'h0100);
        offer(LO_T, 16'h0101);
        offer(HI_T, 16'h0102);
        offer(HI_T, 16'h0103);
        check("R10 stalled handle", out_handle, 16'h0100);
        @(negedge clk);
        check("R10 still stalled", out_handle, 16'h0100);
        out_ready = 1'b1;
        check("R8 order0", out_handle, 16'h0100);
        @(negedge clk);
        check("R8 order1 hi first", out_handle, 16'h0102);
        check("R8 order1 class", out_high, 1);
        @(negedge clk);
        check("R8 order2", out_handle, 16'h0103);
        @(negedge clk);
        check("R8 order3 low last", out_handle, 16'h0101);
        check("R8 order3 class", out_high, 0);
        @(negedge clk);
        check("R8 empty", out_valid, 0);

        // R9: overfill low queue (slot + 4 entries), sixth dropped
        out_ready = 1'b0;
        for (int i = 0; i < 6; i++) offer(LO_T, HW'(16'h0200 + i));
        check("R9 full_lo", full_lo, 1);
        check("R9 drop_lo", drop_lo, 1);
        check("R9 full_hi idle", full_hi, 0);
        for (int i = 0; i < 6; i++) offer(HI_T, HW'(16'h0300 + i));
        check("R9 full_hi", full_hi, 1);
        check("R9 drop_hi", drop_hi, 2);
        check("R9 drop_lo separate", drop_lo, 1);
        for (int i = 0; i < 300; i++) offer(LO_T, 16'hFFFF);
        check("R9 drop_lo saturates", drop_lo, 255);
        check("R9 drop_hi unchanged", drop_hi, 2);

        // drain: slot holds 0x0200, then hi 0x300..0x303, then lo 0x201..0x204
        out_ready = 1'b1;
        check("R8 drain slot", out_handle, 16'h0200);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R8 drain hi", out_handle, 16'h0300 + i);
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R8 drain lo", out_handle, 16'h0201 + i);
        end
        @(negedge clk);
        check("R9 drained empty", out_valid, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule